// File: doc/BRIEF.md
# Drive Command Decoder and Status Packer

This block sits between a host controller and a disc drive. The two sides exchange packets of ten 4-bit fields. When the host marks a command packet as complete, the block decodes the command code into a one-cycle action strobe. For table-of-contents queries it also extracts the sub-code. It keeps a 4-bit status mode nibble that reflects the most recent table-of-contents request.

On a publish request the block captures a status packet. The packet holds the drive state and mode nibbles, the minute, second and frame bytes, and an extension nibble. The block appends an inverted additive checksum. In the same cycle it trims the drive control register, and it raises an interrupt if that interrupt is enabled. The drive mechanics and position tracking are outside this block, and their values arrive as inputs.

Top module: `drvlink_top`

## Requirements
- R1: After reset every field of `stat_pkt` is zero except field 9, the checksum, which reads 0xF. In addition `act_strb`, `toc_sub`, `stat_irq` and `ctl_q` are all zero.
- R2: A cycle with `cmd_valid` high and command code `c` sets exactly one bit of `act_strb` in the next cycle. The command code is field 0, bits [3:0] of `cmd_pkt`. The bit chosen is:
  - 0 for c=0 (status), 1 for c=1 (stop), 2 for c=2 (table-of-contents query), 3 for c=3 (play) and 4 for c=4 (seek);
  - 5 to 9 for c=6 to c=10 (pause, resume, fast forward, rewind, recover);
  - 10 for c=12 (close tray) and 11 for c=13 (open tray);
  - 12 for any other code (unknown).
- R3: A table-of-contents query whose sub-code `s` is 0 to 5 drives `toc_sub` to `s` in the next cycle and sets the status mode nibble to `s`. The sub-code is field 3, bits [15:12] of `cmd_pkt`.
- R4: A table-of-contents query with a sub-code above 5 sets the mode nibble to 0xF. It strobes bit 0 (status) instead of bit 2.
- R5: Any command other than a table-of-contents query leaves the mode nibble unchanged, as seen in the next published packet.
- R6: A publish request loads `stat_pkt` in the next cycle with fields in this order:
  - field 0 is `drv_state` and field 1 is the mode nibble;
  - fields 2–3, 4–5 and 6–7 hold the high and low nibbles of minute, second and frame;
  - field 8 is `drv_ext`.
  Without a publish request the packet holds its value.
- R7: Field 9 of a published packet equals the low 4 bits of the bitwise inverse of the sum of fields 0 to 8.
- R8: A publish request clears bits [3:2] of the drive control register and keeps bits [1:0]. When a host write of `ctl_wd` falls in the same cycle, the write lands first and is then trimmed.
- R9: `stat_irq` pulses high for one cycle after a publish request taken while `irq_en` is high. It stays low otherwise.
- R10: When a command and a publish request fall in the same cycle, the published mode nibble is the value that the command produces.
- R11: Each strobe on `act_strb` lasts one cycle, and no strobe appears without a preceding `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command packet complete |
| cmd_pkt | input | 40 | Command fields, field i at bits [4i+3:4i] |
| act_strb | output | 13 | One-cycle action strobes, one bit per action |
| toc_sub | output | 3 | Last valid table-of-contents sub-code |
| ctl_we | input | 1 | Drive control register write |
| ctl_wd | input | 4 | Drive control write data |
| ctl_q | output | 4 | Drive control register |
| pub_req | input | 1 | Publish status packet |
| irq_en | input | 1 | Status interrupt enable mask bit |
| drv_state | input | 4 | Drive state nibble |
| drv_min | input | 8 | Minute value |
| drv_sec | input | 8 | Second value |
| drv_frm | input | 8 | Frame value |
| drv_ext | input | 4 | Extension nibble |
| stat_pkt | output | 40 | Published status packet, field i at bits [4i+3:4i] |
| stat_irq | output | 1 | Status interrupt, level-4 request |

## Verification
Two events can coincide in one cycle: a table-of-contents command that rewrites the mode nibble, and a publish request that captures that nibble. A host write to the control register can likewise meet a publish that trims it. The bench drives each pair in the same cycle, using both a valid and an out-of-range sub-code. It then judges the published mode field and the control value against the value produced by the command or write, not the stale one. A sweep of all 256 code and sub-code pairs, each followed by a publish, also tracks the mode nibble through every ordering.

// File: rtl/drvlink_pkg.sv
package drvlink_pkg;
  localparam int FW     = 4;
  localparam int NF     = 10;
  localparam int PKT_W  = FW * NF;
  localparam int NACT   = 13;
  localparam int SUB_W  = 3;
  localparam int CTL_W  = 4;
  localparam int CTL_KP = 2;

  typedef enum logic [3:0] {
    ACT_STATUS  = 4'd0,
    ACT_STOP    = 4'd1,
    ACT_TOC     = 4'd2,
    ACT_PLAY    = 4'd3,
    ACT_SEEK    = 4'd4,
    ACT_PAUSE   = 4'd5,
    ACT_RESUME  = 4'd6,
    ACT_FFWD    = 4'd7,
    ACT_REWIND  = 4'd8,
    ACT_RECOVER = 4'd9,
    ACT_CLOSE   = 4'd10,
    ACT_OPEN    = 4'd11,
    ACT_UNKNOWN = 4'd12
  } act_e;
endpackage

// File: rtl/drvlink_cmd_dec.sv
module drvlink_cmd_dec
  import drvlink_pkg::*;
#(
  parameter int FLD_W  = FW,
  parameter int N_FLD  = NF,
  parameter int N_ACT  = NACT,
  parameter int SUBW   = SUB_W,
  parameter int TOC_MAX = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [FLD_W*N_FLD-1:0] cmd_pkt,
  output logic [N_ACT-1:0]       act_strb,
  output logic [SUBW-1:0]        toc_sub,
  output logic [FLD_W-1:0]       mode_nxt
);
  localparam int SUB_LSB = 3 * FLD_W;

  logic [FLD_W-1:0] code;
  logic [FLD_W-1:0] sub;
  logic             sub_ok;
  act_e             act_sel;
  logic [N_ACT-1:0] strb_d, strb_q;
  logic [SUBW-1:0]  toc_d, toc_q;
  logic [FLD_W-1:0] mode_q;

  assign code   = cmd_pkt[FLD_W-1:0];
  assign sub    = cmd_pkt[SUB_LSB +: FLD_W];
  assign sub_ok = (sub <= FLD_W'(TOC_MAX));

  always_comb begin
    unique case (code)
      4'd0:    act_sel = ACT_STATUS;
      4'd1:    act_sel = ACT_STOP;
      4'd2:    act_sel = sub_ok ? ACT_TOC : ACT_STATUS;
      4'd3:    act_sel = ACT_PLAY;
      4'd4:    act_sel = ACT_SEEK;
      4'd6:    act_sel = ACT_PAUSE;
      4'd7:    act_sel = ACT_RESUME;
      4'd8:    act_sel = ACT_FFWD;
      4'd9:    act_sel = ACT_REWIND;
      4'd10:   act_sel = ACT_RECOVER;
      4'd12:   act_sel = ACT_CLOSE;
      4'd13:   act_sel = ACT_OPEN;
      default: act_sel = ACT_UNKNOWN;
    endcase
  end

  always_comb begin
    strb_d   = '0;
    toc_d    = toc_q;
    mode_nxt = mode_q;
    if (cmd_valid) begin
      strb_d[act_sel] = 1'b1;
      if (code == 4'd2) begin
        if (sub_ok) begin
          toc_d    = sub[SUBW-1:0];
          mode_nxt = sub;
        end else begin
          mode_nxt = '1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
      toc_q  <= '0;
      mode_q <= '0;
    end else begin
      strb_q <= strb_d;
      if (cmd_valid) begin
        toc_q  <= toc_d;
        mode_q <= mode_nxt;
      end
    end
  end

  assign act_strb = strb_q;
  assign toc_sub  = toc_q;

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_strb));
  p_strobe_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_strb != '0) |-> $past(cmd_valid));
  p_toc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_strb[ACT_TOC] |-> (toc_sub <= SUBW'(TOC_MAX)));
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(mode_q));
endmodule

// File: rtl/drvlink_stat_pack.sv
module drvlink_stat_pack
  import drvlink_pkg::*;
#(
  parameter int FLD_W = FW,
  parameter int N_FLD = NF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pub_req,
  input  logic                   irq_en,
  input  logic [FLD_W-1:0]       drv_state,
  input  logic [FLD_W-1:0]       mode_in,
  input  logic [2*FLD_W-1:0]     drv_min,
  input  logic [2*FLD_W-1:0]     drv_sec,
  input  logic [2*FLD_W-1:0]     drv_frm,
  input  logic [FLD_W-1:0]       drv_ext,
  output logic [FLD_W*N_FLD-1:0] stat_pkt,
  output logic                   stat_irq
);
  localparam int SUM_W  = FLD_W + $clog2(N_FLD);
  localparam int CK_IDX = N_FLD - 1;

  logic [FLD_W-1:0] fld_d [N_FLD];
  logic [FLD_W-1:0] fld_q [N_FLD];
  logic [SUM_W-1:0] sum_d;
  logic [SUM_W-1:0] sum_q;
  logic             irq_q;

  always_comb begin
    fld_d[0] = drv_state;
    fld_d[1] = mode_in;
    fld_d[2] = drv_min[2*FLD_W-1:FLD_W];
    fld_d[3] = drv_min[FLD_W-1:0];
    fld_d[4] = drv_sec[2*FLD_W-1:FLD_W];
    fld_d[5] = drv_sec[FLD_W-1:0];
    fld_d[6] = drv_frm[2*FLD_W-1:FLD_W];
    fld_d[7] = drv_frm[FLD_W-1:0];
    fld_d[8] = drv_ext;
    sum_d = '0;
    for (int i = 0; i < CK_IDX; i++) sum_d = sum_d + SUM_W'(fld_d[i]);
    fld_d[CK_IDX] = ~sum_d[FLD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_FLD; i++) fld_q[i] <= (i == CK_IDX) ? '1 : '0;
      irq_q <= 1'b0;
    end else begin
      if (pub_req) begin
        for (int i = 0; i < N_FLD; i++) fld_q[i] <= fld_d[i];
      end
      irq_q <= pub_req & irq_en;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_FLD; g++) begin : g_flat
      assign stat_pkt[g*FLD_W +: FLD_W] = fld_q[g];
    end
  endgenerate

  assign stat_irq = irq_q;

  always_comb begin
    sum_q = '0;
    for (int i = 0; i < CK_IDX; i++) sum_q = sum_q + SUM_W'(fld_q[i]);
  end

  p_checksum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fld_q[CK_IDX] == ~sum_q[FLD_W-1:0]);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_irq |-> $past(pub_req && irq_en));
  p_pkt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pub_req |=> $stable(stat_pkt));
endmodule

// File: rtl/drvlink_ctl_reg.sv
module drvlink_ctl_reg
  import drvlink_pkg::*;
#(
  parameter int CW   = CTL_W,
  parameter int KEEP = CTL_KP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          trim,
  output logic [CW-1:0] ctl_q
);
  localparam logic [CW-1:0] KEEP_MASK = CW'((1 << KEEP) - 1);

  logic [CW-1:0] ctl_d, ctl_r;

  always_comb begin
    ctl_d = ctl_r;
    if (wr_en) ctl_d = wr_data;
    if (trim)  ctl_d = ctl_d & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ctl_r <= '0;
    else if (wr_en || trim) ctl_r <= ctl_d;
  end

  assign ctl_q = ctl_r;

  p_trim_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trim |=> (ctl_q[CW-1:KEEP] == '0));
  p_trim_keeps_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trim && !wr_en) |=> (ctl_q[KEEP-1:0] == $past(ctl_q[KEEP-1:0])));
endmodule

// File: rtl/drvlink_top.sv
module drvlink_top
  import drvlink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [PKT_W-1:0] cmd_pkt,
  output logic [NACT-1:0]  act_strb,
  output logic [SUB_W-1:0] toc_sub,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             pub_req,
  input  logic             irq_en,
  input  logic [FW-1:0]    drv_state,
  input  logic [2*FW-1:0]  drv_min,
  input  logic [2*FW-1:0]  drv_sec,
  input  logic [2*FW-1:0]  drv_frm,
  input  logic [FW-1:0]    drv_ext,
  output logic [PKT_W-1:0] stat_pkt,
  output logic             stat_irq
);
  logic [FW-1:0] mode_nxt;

  drvlink_cmd_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_pkt   (cmd_pkt),
    .act_strb  (act_strb),
    .toc_sub   (toc_sub),
    .mode_nxt  (mode_nxt)
  );

  drvlink_stat_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .pub_req   (pub_req),
    .irq_en    (irq_en),
    .drv_state (drv_state),
    .mode_in   (mode_nxt),
    .drv_min   (drv_min),
    .drv_sec   (drv_sec),
    .drv_frm   (drv_frm),
    .drv_ext   (drv_ext),
    .stat_pkt  (stat_pkt),
    .stat_irq  (stat_irq)
  );

  drvlink_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_we),
    .wr_data (ctl_wd),
    .trim    (pub_req),
    .ctl_q   (ctl_q)
  );

  p_same_cycle_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pub_req && cmd_valid && cmd_pkt[3:0] == 4'd2) |=> (stat_pkt[7:4] != 4'd0 ||
      $past(cmd_pkt[15:12]) == 4'd0));
endmodule

// File: tb/drvlink_top_bench.sv
`timescale 1ns/1ps
module drvlink_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [39:0] cmd_pkt;
  logic [12:0] act_strb;
  logic [2:0]  toc_sub;
  logic        ctl_we;
  logic [3:0]  ctl_wd;
  logic [3:0]  ctl_q;
  logic        pub_req;
  logic        irq_en;
  logic [3:0]  drv_state;
  logic [7:0]  drv_min, drv_sec, drv_frm;
  logic [3:0]  drv_ext;
  logic [39:0] stat_pkt;
  logic        stat_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  drvlink_top u_drvlink_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pkt(cmd_pkt),
    .act_strb(act_strb), .toc_sub(toc_sub), .ctl_we(ctl_we), .ctl_wd(ctl_wd),
    .ctl_q(ctl_q), .pub_req(pub_req), .irq_en(irq_en), .drv_state(drv_state),
    .drv_min(drv_min), .drv_sec(drv_sec), .drv_frm(drv_frm), .drv_ext(drv_ext),
    .stat_pkt(stat_pkt), .stat_irq(stat_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_bit(input int code, input int sub);
    if (code == 2) return (sub <= 5) ? 2 : 0;
    if (code <= 4) return code;
    if (code >= 6 && code <= 10) return code - 1;
    if (code == 12) return 10;
    if (code == 13) return 11;
    return 12;
  endfunction

  function automatic logic [39:0] exp_pkt(input logic [3:0] st, input logic [3:0] md,
      input logic [7:0] mi, input logic [7:0] se, input logic [7:0] fr,
      input logic [3:0] ex);
    int s;
    logic [3:0] ck;
    s  = st + md + mi[7:4] + mi[3:0] + se[7:4] + se[3:0] + fr[7:4] + fr[3:0] + ex;
    ck = 4'(~s);
    return {ck, ex, fr[3:0], fr[7:4], se[3:0], se[7:4], mi[3:0], mi[7:4], md, st};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] mode_m;
    logic [12:0] e_strb;
    logic [2:0]  toc_m;
    rst_n = 1'b0; cmd_valid = 0; cmd_pkt = '0; ctl_we = 0; ctl_wd = '0;
    pub_req = 0; irq_en = 0; drv_state = '0; drv_min = '0; drv_sec = '0;
    drv_frm = '0; drv_ext = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(stat_pkt == {4'hF, 36'h0}, "R1 pkt", stat_pkt, {4'hF, 36'h0});
    chk(act_strb == 0, "R1 strb", act_strb, 0);
    chk(toc_sub == 0, "R1 toc", toc_sub, 0);
    chk(ctl_q == 0, "R1 ctl", ctl_q, 0);
    chk(stat_irq == 0, "R1 irq", stat_irq, 0);

    // R2 R3 R4 R5 R11: full code x sub-code sweep, each followed by publish
    mode_m = 4'h0;
    toc_m  = 3'd0;
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 16; s++) begin
        cmd_valid = 1;
        cmd_pkt = {24'(c * 40503 + s), 4'(s), 4'(c ^ s), 4'(~c), 4'(c)};
        step();
        cmd_valid = 0;
        e_strb = 13'(1) << exp_bit(c, s);
        if (c == 2) begin
          if (s <= 5) begin mode_m = 4'(s); toc_m = 3'(s); end
          else mode_m = 4'hF;
        end
        chk(act_strb == e_strb, (c == 2 && s > 5) ? "R4 strb" : "R2 strb",
            act_strb, e_strb);
        chk(toc_sub == toc_m, "R3 toc_sub", toc_sub, toc_m);
        pub_req = 1;
        step();
        pub_req = 0;
        chk(act_strb == 0, "R11 one cycle", act_strb, 0);
        chk(stat_pkt[7:4] == mode_m,
            (c == 2) ? ((s <= 5) ? "R3 mode" : "R4 mode") : "R5 mode kept",
            stat_pkt[7:4], mode_m);
      end
    end

    // R6 R7 R9: packet layout, checksum and interrupt over many patterns
    for (int i = 0; i < 512; i++) begin
      logic [39:0] e;
      drv_state = 4'(i);
      drv_min   = 8'(i * 37 + 5);
      drv_sec   = 8'(i * 11 + 200);
      drv_frm   = 8'(i ^ 8'hA5);
      drv_ext   = 4'(i >> 4);
      irq_en    = i[0];
      if (i == 511) begin
        drv_state = 4'hF; drv_min = 8'hFF; drv_sec = 8'hFF; drv_frm = 8'hFF;
        drv_ext = 4'hF;
      end
      e = exp_pkt(drv_state, mode_m, drv_min, drv_sec, drv_frm, drv_ext);
      pub_req = 1;
      step();
      pub_req = 0;
      chk(stat_pkt[35:0] == e[35:0], "R6 layout", stat_pkt, e);
      chk(stat_pkt[39:36] == e[39:36], "R7 checksum", stat_pkt[39:36], e[39:36]);
      chk(stat_irq == irq_en, "R9 irq", stat_irq, irq_en);
      drv_state = ~drv_state;
      step();
      chk(stat_irq == 0, "R9 pulse end", stat_irq, 0);
      chk(stat_pkt == e, "R6 hold", stat_pkt, e);
    end
    // all-ones: sum 135 -> low nibble 7 -> checksum 8
    chk(stat_pkt[39:36] == 4'h8, "R7 all ones", stat_pkt[39:36], 4'h8);

    // R8 control register
    ctl_we = 1; ctl_wd = 4'hF;
    step();
    ctl_we = 0;
    chk(ctl_q == 4'hF, "R8 write", ctl_q, 4'hF);
    pub_req = 1;
    step();
    pub_req = 0;
    chk(ctl_q == 4'h3, "R8 trim", ctl_q, 4'h3);
    ctl_we = 1; ctl_wd = 4'hE; pub_req = 1;
    step();
    ctl_we = 0; pub_req = 0;
    chk(ctl_q == 4'h2, "R8 write with trim", ctl_q, 4'h2);

    // R10 same-cycle command and publish
    irq_en = 0;
    cmd_valid = 1; cmd_pkt = {24'h0, 4'd3, 8'h00, 4'd2}; pub_req = 1;
    step();
    cmd_valid = 0; pub_req = 0;
    chk(stat_pkt[7:4] == 4'd3, "R10 mode valid", stat_pkt[7:4], 3);
    chk(act_strb == 13'h4, "R10 strb", act_strb, 13'h4);
    cmd_valid = 1; cmd_pkt = {24'h0, 4'd9, 8'h00, 4'd2}; pub_req = 1;
    step();
    cmd_valid = 0; pub_req = 0;
    chk(stat_pkt[7:4] == 4'hF, "R10 mode invalid", stat_pkt[7:4], 4'hF);
    cmd_valid = 1; cmd_pkt = {24'h0, 4'd1, 8'h00, 4'd7}; pub_req = 1;
    step();
    cmd_valid = 0; pub_req = 0;
    chk(stat_pkt[7:4] == 4'hF, "R10 non-query keeps mode", stat_pkt[7:4], 4'hF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule